// File: doc/BRIEF.md
# Firmware Mailbox with Event Status

This block is a small register bank on a synchronous I/O port. It lets an operating system and a system-management handler pass single bytes to each other. It holds one 8-bit data register for each direction and one 16-bit status register. Storing a byte in the inbound register flags the transfer and raises a level request toward the management handler. Storing a byte in the outbound register flags the transfer and raises a level interrupt toward the OS, on one of three lines picked by a select input.

The status register also latches three kinds of one-cycle message pulses that arrive from an upstream hub link:

- a system-error request
- a management-interrupt request
- a system-control-interrupt request

Software reads the status register and clears any bit by writing a 1 to that bit position. Reads are combinational and have no side effects. No register can be locked.

Top module: `fw_mailbox`

## Requirements
- R1: After reset, both data registers read 00h, the status register reads 0000h, `smi_req_o` is low and `os_irq_o` is all zero.
- R2: A write to offset 02h stores the low 8 bits of `bus_wdata_i` in the inbound register and ignores the upper 8 bits. A read of 02h returns that byte zero-extended in the same cycle.
- R3: Any write to offset 02h sets status bit 1. From the next cycle `smi_req_o` is high, and it stays high until software clears bit 1.
- R4: A write to offset 03h stores the low byte in the outbound register. A read of 03h returns that byte zero-extended.
- R5: Any write to offset 03h sets status bit 2. While bit 2 is set, `os_irq_o` is driven according to `irq_sel_i`:
  - codes 0, 1 and 2 drive only `os_irq_o[0]`, `[1]` or `[2]` respectively;
  - code 3 drives no line.
- R6: A one-cycle pulse on `evt_serr_i` sets status bit 12. A pulse on `evt_smi_i` sets bit 10. A pulse on `evt_sci_i` sets bit 9. Each bit stays set after its pulse ends.
- R7: A write to offset 04h clears every status bit 12, 10, 9, 2 or 1 whose position holds a 1 in the write data. Positions written with 0 keep their value.
- R8: Status bits 15:13, 11, 8:3 and 0 always read 0. Writing 1 to them changes nothing.
- R9: If an event pulse and a write-1-to-clear reach the same status bit in the same cycle, the bit is set afterwards.
- R10: Reads have no side effects. Offsets other than 02h, 03h and 04h read 0000h, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Write strobe for the addressed register |
| bus_addr_i | input | 8 | Register offset from the block base |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for `bus_addr_i`, combinational |
| evt_serr_i | input | 1 | Link message pulse: system-error request |
| evt_smi_i | input | 1 | Link message pulse: management-interrupt request |
| evt_sci_i | input | 1 | Link message pulse: system-control-interrupt request |
| irq_sel_i | input | 2 | OS interrupt line select; code 3 disables |
| smi_req_o | output | 1 | Level request toward the management handler |
| os_irq_o | output | 3 | Level OS interrupt lines, at most one active |

## Verification
The bench builds the block with its default parameters: an 8-bit offset space, 8-bit mailbox bytes, a 16-bit status word and three OS interrupt lines selected by a 2-bit code. With these values every select code can be driven, including the disable code 3. Unmapped offsets next to and below the decoded window can be reached. Every reserved status position can be hit with all-ones writes. The bench also covers the same-cycle collision of a link pulse with a clear.

// File: rtl/fw_mailbox_pkg.sv
package fw_mailbox_pkg;

    // Register offsets; software depends on these.
    localparam int OFF_INBOX  = 2;
    localparam int OFF_OUTBOX = 3;
    localparam int OFF_STATUS = 4;

    // Index of each latched flag in the flag bank.
    localparam int FL_SWMGMT = 0;
    localparam int FL_OSMSG  = 1;
    localparam int FL_SERR   = 2;
    localparam int FL_LMGMT  = 3;
    localparam int FL_LSCI   = 4;
    localparam int NFLAG     = 5;

    // Bit position of each flag inside the status word.
    function automatic int flag_pos(input int idx);
        case (idx)
            FL_SWMGMT: return 1;
            FL_OSMSG:  return 2;
            FL_SERR:   return 12;
            FL_LMGMT:  return 10;
            default:   return 9;
        endcase
    endfunction

endpackage

// File: rtl/mbx_w1c_bank.sv
module mbx_w1c_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);

    logic [N-1:0] q_d, q_q;

    // Set has priority over clear for every bit.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            if (set_i[i])      q_d[i] = 1'b1;
            else if (clr_i[i]) q_d[i] = 1'b0;
            else               q_d[i] = q_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign q_o = q_q;

    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((q_q & $past(set_i)) == $past(set_i)));

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i & clr_i) != '0) |=> ((q_q & $past(set_i & clr_i)) == $past(set_i & clr_i)));

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((q_q & $past(clr_i & ~set_i)) == '0));

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0 && clr_i == '0) |=> $stable(q_q));

endmodule

// File: rtl/mbx_irq_route.sv
module mbx_irq_route #(
    parameter int NIRQ  = 3,
    parameter int SEL_W = 2
) (
    input  logic             req_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [NIRQ-1:0]  irq_o
);

    // Codes at or above NIRQ reach no line.
    for (genvar g = 0; g < NIRQ; g++) begin : g_line
        assign irq_o[g] = req_i && (sel_i == SEL_W'(g));
    end

    always_comb begin
        // R5
        os_irq_onehot_chk: assert ($onehot0(irq_o));
        // R5
        os_irq_req_chk: assert (req_i || irq_o == '0);
    end

endmodule

// File: rtl/fw_mailbox.sv
module fw_mailbox
    import fw_mailbox_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int STAT_W = 16,
    parameter int NIRQ   = 3,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [STAT_W-1:0] bus_wdata_i,
    output logic [STAT_W-1:0] bus_rdata_o,
    input  logic              evt_serr_i,
    input  logic              evt_smi_i,
    input  logic              evt_sci_i,
    input  logic [SEL_W-1:0]  irq_sel_i,
    output logic              smi_req_o,
    output logic [NIRQ-1:0]   os_irq_o
);

    localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(OFF_INBOX);
    localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(OFF_OUTBOX);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STATUS);

    typedef struct packed {
        logic [DATA_W-1:0] inbox;
        logic [DATA_W-1:0] outbox;
    } mbx_regs_t;

    mbx_regs_t         regs_d, regs_q;
    logic [NFLAG-1:0]  flag_set, flag_clr, flags;
    logic [STAT_W-1:0] stat_view;
    logic              wr_in, wr_out, wr_stat;

    always_comb begin
        wr_in   = bus_wr_i && (bus_addr_i == A_IN);
        wr_out  = bus_wr_i && (bus_addr_i == A_OUT);
        wr_stat = bus_wr_i && (bus_addr_i == A_STAT);

        regs_d = regs_q;
        if (wr_in)  regs_d.inbox  = bus_wdata_i[DATA_W-1:0];
        if (wr_out) regs_d.outbox = bus_wdata_i[DATA_W-1:0];

        flag_set            = '0;
        flag_set[FL_SWMGMT] = wr_in;
        flag_set[FL_OSMSG]  = wr_out;
        flag_set[FL_SERR]   = evt_serr_i;
        flag_set[FL_LMGMT]  = evt_smi_i;
        flag_set[FL_LSCI]   = evt_sci_i;

        for (int i = 0; i < NFLAG; i++)
            flag_clr[i] = wr_stat && bus_wdata_i[flag_pos(i)];

        stat_view = '0;
        for (int i = 0; i < NFLAG; i++)
            stat_view[flag_pos(i)] = flags[i];

        bus_rdata_o = '0;
        if (bus_addr_i == A_IN)        bus_rdata_o = STAT_W'(regs_q.inbox);
        else if (bus_addr_i == A_OUT)  bus_rdata_o = STAT_W'(regs_q.outbox);
        else if (bus_addr_i == A_STAT) bus_rdata_o = stat_view;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    mbx_w1c_bank #(.N(NFLAG)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (flag_set),
        .clr_i (flag_clr),
        .q_o   (flags)
    );

    mbx_irq_route #(.NIRQ(NIRQ), .SEL_W(SEL_W)) u_route (
        .req_i (flags[FL_OSMSG]),
        .sel_i (irq_sel_i),
        .irq_o (os_irq_o)
    );

    assign smi_req_o = flags[FL_SWMGMT];

    // R3
    inbox_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_in |=> smi_req_o);

    // R2
    inbox_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_in |=> (regs_q.inbox == $past(bus_wdata_i[DATA_W-1:0])));

    // R10
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_in || wr_out) |=> $stable(regs_q));

    // R5
    outbox_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_out && irq_sel_i != '1 && $stable(irq_sel_i)) |=> (os_irq_o != '0));

endmodule

// File: tb/fw_mailbox_tb.sv
module fw_mailbox_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        e_serr = 1'b0, e_smi = 1'b0, e_sci = 1'b0;
    logic [1:0]  sel = 2'd0;
    logic        smi;
    logic [2:0]  irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    fw_mailbox u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .evt_serr_i(e_serr),
        .evt_smi_i(e_smi), .evt_sci_i(e_sci), .irq_sel_i(sel),
        .smi_req_o(smi), .os_irq_o(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0; wdata = '0;
    endtask

    task automatic read_check(input string req, input logic [7:0] a, input logic [15:0] exp);
        addr = a; #1;
        check(req, rdata, exp);
    endtask

    task automatic t_reset;
        read_check("R1", 8'h02, 16'h0000);
        read_check("R1", 8'h03, 16'h0000);
        read_check("R1", 8'h04, 16'h0000);
        check("R1", {15'd0, smi}, 16'd0);
        check("R1", {13'd0, irq}, 16'd0);
    endtask

    task automatic t_inbox;
        bus_write(8'h02, 16'h12C3);
        read_check("R2", 8'h02, 16'h00C3);
        check("R3", {15'd0, smi}, 16'd1);
        read_check("R3", 8'h04, 16'h0002);
        @(negedge clk);
        read_check("R10", 8'h04, 16'h0002);
        check("R3", {15'd0, smi}, 16'd1);
        bus_write(8'h02, 16'h00A5);
        read_check("R2", 8'h02, 16'h00A5);
        bus_write(8'h04, 16'h0002);
        check("R3", {15'd0, smi}, 16'd0);
        read_check("R7", 8'h04, 16'h0000);
        read_check("R2", 8'h02, 16'h00A5);
    endtask

    task automatic t_outbox;
        for (int s = 0; s < 4; s++) begin
            sel = 2'(s);
            bus_write(8'h03, 16'(8'h30 + s));
            read_check("R4", 8'h03, 16'(8'h30 + s));
            read_check("R5", 8'h04, 16'h0004);
            check("R5", {13'd0, irq}, (s < 3) ? 16'(1 << s) : 16'd0);
            bus_write(8'h04, 16'h0004);
            check("R5", {13'd0, irq}, 16'd0);
        end
        sel = 2'd0;
        check("R3", {15'd0, smi}, 16'd0);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: e_serr = 1'b1;
            1: e_smi  = 1'b1;
            default: e_sci = 1'b1;
        endcase
        @(negedge clk);
        e_serr = 1'b0; e_smi = 1'b0; e_sci = 1'b0;
    endtask

    task automatic t_events;
        pulse(0);
        read_check("R6", 8'h04, 16'h1000);
        pulse(1);
        read_check("R6", 8'h04, 16'h1400);
        pulse(2);
        @(negedge clk);
        read_check("R6", 8'h04, 16'h1600);
        bus_write(8'h04, 16'h0000);
        read_check("R7", 8'h04, 16'h1600);
        bus_write(8'h04, 16'h0400);
        read_check("R7", 8'h04, 16'h1200);
        bus_write(8'h04, 16'hFFFF);
        read_check("R7", 8'h04, 16'h0000);
    endtask

    task automatic t_reserved;
        bus_write(8'h04, 16'hFFFF);
        read_check("R8", 8'h04, 16'h0000);
        pulse(0);
        bus_write(8'h04, 16'hEFF9);
        read_check("R8", 8'h04, 16'h1000);
        bus_write(8'h04, 16'h1000);
        read_check("R8", 8'h04, 16'h0000);
    endtask

    task automatic t_set_wins;
        @(negedge clk);
        wr = 1'b1; addr = 8'h04; wdata = 16'h0200; e_sci = 1'b1;
        @(negedge clk);
        wr = 1'b0; e_sci = 1'b0; wdata = '0;
        read_check("R9", 8'h04, 16'h0200);
        bus_write(8'h04, 16'h0200);
        read_check("R9", 8'h04, 16'h0000);
    endtask

    task automatic t_unmapped;
        bus_write(8'h05, 16'hFFFF);
        bus_write(8'h00, 16'hFFFF);
        read_check("R10", 8'h05, 16'h0000);
        read_check("R10", 8'h00, 16'h0000);
        read_check("R10", 8'h02, 16'h00A5);
        read_check("R10", 8'h03, 16'h0033);
        read_check("R10", 8'h04, 16'h0000);
        check("R10", {12'd0, smi, irq}, 16'd0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_inbox();
        t_outbox();
        t_events();
        t_reserved();
        t_set_wins();
        t_unmapped();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule